// File: doc/BRIEF.md
# Host Watchdog Countdown Timer

This block is the watchdog that a network controller keeps on its host. Once armed, it counts down in quarter-second ticks from a timeout picked by a 3-bit code. The codes give an exponential ladder running from a quarter second to a little over an hour. Every finished transmit or receive on the controller raises an activity strobe, and that strobe refills the count to the full programmed value. If the host stops making progress, the count runs out. The block then pulls its power-good output low for a fixed number of system clock cycles, so that the host reboots.

Software arms the timer by strobing a new timeout code while its enable bit is set. The same strobe with the enable clear disarms the timer. A board strap can also hold the timer armed. While that strap is set, a software cancel request is ignored, and a load strobe always arms the timer. In the legacy device mode, a set strap arms the timer by itself as the block leaves reset, using a 4-minute timeout. The quarter-second tick comes from a prescaler outside the block, as one-cycle strobes.

Top module: `host_watchdog`

## Requirements
- R1: While reset is held, and after a release with the legacy mode input low, `running` is 0 and `host_power_ok` is 1.
- R2: The timeout for code c (the `tmo_code` value at the load strobe) is T(c) ticks, with T = 1, 4, 16, 64, 240, 960, 3840, 15360 for c = 0..7. After a start, the count survives T(c)-1 ticks and expires on tick number T(c).
- R3: A `tmo_load` strobe while `sw_en` or `hw_strap` is 1 starts the timer with T(`tmo_code`), reloading the count even when the timer is already running.
- R4: A `tmo_load` strobe while both `sw_en` and `hw_strap` are 0 stops the timer.
- R5: An `activity` strobe while running refills the count to the programmed T(c). An `activity` strobe while idle has no effect.
- R6: `cancel_req` stops the timer when `hw_strap` is 0. When `hw_strap` is 1, it leaves the timer and its count untouched.
- R7: On the tick that exhausts the count, `running` falls and `host_power_ok` goes low, both visible after that same clock edge. `host_power_ok` stays low for exactly PULSE_CYCLES clock cycles.
- R8: After expiry the timer stays idle. Further ticks start nothing and cause no further pulse until the timer is started again.
- R9: With `legacy_mode` and `hw_strap` both 1 when reset is released, the timer starts by itself with a 960-tick (4-minute) timeout.
- R10: When `activity` and `tick_qs` arrive in the same cycle, the refill wins and the tick is dropped, so no expiry happens on that cycle.
- R11: When `tmo_load` and `cancel_req` arrive in the same cycle, the load strobe decides the outcome.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_qs | input | 1 | One-cycle strobe marking each quarter-second tick |
| tmo_code | input | 3 | Timeout selection code, taken at `tmo_load` |
| tmo_load | input | 1 | Strobe that latches `tmo_code` and arms or disarms the timer |
| sw_en | input | 1 | Software enable bit |
| hw_strap | input | 1 | Board strap that holds the timer armed and blocks cancel |
| legacy_mode | input | 1 | Selects the legacy device mode, which arms the timer at reset when strapped |
| activity | input | 1 | Strobe from a completed transmit or receive |
| cancel_req | input | 1 | Software request to stop the timer |
| host_power_ok | output | 1 | Host power-good line, driven low for the reboot pulse |
| running | output | 1 | High while the countdown is armed |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a refill strobe and the tick that would bring the count to zero. The second pair is a load strobe and a cancel request. The bench provokes the first pair by running a short timeout down to its last tick and raising `activity` together with `tick_qs`. It judges the result by checking that `running` stays high and that a full new timeout is needed before any pulse appears. The second pair is provoked by raising `tmo_load` with the enable set and `cancel_req` in one cycle, and is judged by `running` being high afterwards.

// File: rtl/hwd_pkg.sv
package hwd_pkg;

  localparam int unsigned CODE_W  = 3;
  localparam int unsigned N_CODES = 1 << CODE_W;
  // Number of ticks in one minute: 60 s at four ticks per second.
  localparam int unsigned MINUTE_TICKS = 240;

  // Timeout in quarter-second ticks. Codes in the lower half step by four
  // starting at a single tick. Codes in the upper half step by four
  // starting at one minute.
  function automatic int unsigned hwd_code_ticks(input int unsigned code);
    if (code < N_CODES / 2)
      return 32'd1 << (2 * code);
    else
      return MINUTE_TICKS << (2 * (code - N_CODES / 2));
  endfunction

  function automatic int unsigned hwd_max_ticks();
    int unsigned m;
    m = 0;
    for (int unsigned c = 0; c < N_CODES; c++)
      if (hwd_code_ticks(c) > m) m = hwd_code_ticks(c);
    return m;
  endfunction

endpackage

// File: rtl/hwd_rst_sync.sv
module hwd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/hwd_reload_sel.sv
module hwd_reload_sel
  import hwd_pkg::*;
#(
  parameter int unsigned CNT_W        = 14,
  parameter int unsigned DEFAULT_CODE = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  new_val,
  output logic [CNT_W-1:0]  prog_val
);

  localparam logic [CNT_W-1:0] DEF_VAL = CNT_W'(hwd_code_ticks(DEFAULT_CODE));

  logic [CNT_W-1:0] ladder [N_CODES];
  logic [CNT_W-1:0] prog_q;
  logic [CNT_W-1:0] prog_d;

  genvar gi;
  generate
    for (gi = 0; gi < N_CODES; gi++) begin : g_ladder
      assign ladder[gi] = CNT_W'(hwd_code_ticks(gi));
    end
  endgenerate

  assign new_val = ladder[code];

  always_comb begin
    prog_d = new_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prog_q <= DEF_VAL;
    else if (load_en) prog_q <= prog_d;
  end

  assign prog_val = prog_q;

  // R2: once a code has been latched, the programmed value never reads as zero
  p_prog_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load_en) |-> prog_val != '0);

endmodule

// File: rtl/hwd_countdown.sv
module hwd_countdown #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             reload,
  input  logic             tick,
  input  logic [CNT_W-1:0] start_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic             running,
  output logic             expire
);

  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // Priority: start, then stop, then refill, then tick.
  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (start) begin
      run_d = 1'b1;
      cnt_d = start_val;
    end else if (stop) begin
      run_d = 1'b0;
      cnt_d = '0;
    end else if (run_q) begin
      if (reload) begin
        cnt_d = reload_val;
      end else if (tick) begin
        if (cnt_q <= CNT_W'(1)) begin
          run_d  = 1'b0;
          cnt_d  = '0;
          expire = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
  end

  assign cnt_en = start | stop | (run_q & (reload | tick));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (cnt_en) begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assign running = run_q;

  // R7: an armed counter never sits at zero
  p_live_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> cnt_q != '0);

  // R7: a lone tick takes exactly one unit off a count above one
  p_tick_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick && !start && !stop && !reload && cnt_q > CNT_W'(1))
      |=> (run_q && cnt_q == $past(cnt_q) - 1'b1));

  // R5 and R10: a refill wins over a tick and restores the programmed value
  p_refill_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && reload && !start && !stop) |=> (run_q && cnt_q == $past(reload_val)));

  // R8: an idle counter stays idle until started
  p_idle_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start) |=> !run_q);

endmodule

// File: rtl/hwd_pulse.sv
module hwd_pulse #(
  parameter int unsigned PULSE_CYCLES = 36
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);

  localparam int unsigned PW_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [PW_W-1:0] PW_FULL = PW_W'(PULSE_CYCLES);

  logic [PW_W-1:0] left_q, left_d;
  logic            left_en;

  always_comb begin
    if (fire)              left_d = PW_FULL;
    else if (left_q != '0) left_d = left_q - 1'b1;
    else                   left_d = left_q;
  end

  assign left_en = fire | (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       left_q <= '0;
    else if (left_en) left_q <= left_d;
  end

  assign active = left_q != '0;

  // R7: a firing request opens a pulse of the full width
  p_pulse_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (active && left_q == PW_FULL));

  // R7: an open pulse drains by one per cycle unless refired
  p_pulse_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !fire) |=> left_q == $past(left_q) - 1'b1);

endmodule

// File: rtl/host_watchdog.sv
module host_watchdog
  import hwd_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 36,
  parameter int unsigned DEFAULT_CODE = 5,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_qs,
  input  logic [CODE_W-1:0] tmo_code,
  input  logic              tmo_load,
  input  logic              sw_en,
  input  logic              hw_strap,
  input  logic              legacy_mode,
  input  logic              activity,
  input  logic              cancel_req,
  output logic              host_power_ok,
  output logic              running
);

  localparam int unsigned CNT_W = $clog2(hwd_max_ticks() + 1);

  logic             srst_n;
  logic             por_q;
  logic             arm_ok;
  logic             start_sw, start_por, start;
  logic             stop;
  logic             expire;
  logic             pulse_on;
  logic [CNT_W-1:0] new_val, prog_val, start_val;

  hwd_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  // One-cycle marker for the first edge after reset is released
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)    por_q <= 1'b1;
    else if (por_q) por_q <= 1'b0;
  end

  // A load strobe decides the outcome by itself; cancel only acts without
  // one, and never while the strap is set.
  always_comb begin
    arm_ok    = sw_en | hw_strap;
    start_sw  = tmo_load & arm_ok;
    start_por = por_q & legacy_mode & hw_strap;
    start     = start_sw | start_por;
    stop      = (tmo_load & ~arm_ok) | (cancel_req & ~hw_strap & ~tmo_load);
    start_val = tmo_load ? new_val : prog_val;
  end

  hwd_reload_sel #(
    .CNT_W        (CNT_W),
    .DEFAULT_CODE (DEFAULT_CODE)
  ) u_sel (
    .clk      (clk),
    .rst_n    (srst_n),
    .load_en  (tmo_load),
    .code     (tmo_code),
    .new_val  (new_val),
    .prog_val (prog_val)
  );

  hwd_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (srst_n),
    .start      (start),
    .stop       (stop),
    .reload     (activity),
    .tick       (tick_qs),
    .start_val  (start_val),
    .reload_val (prog_val),
    .running    (running),
    .expire     (expire)
  );

  hwd_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk    (clk),
    .rst_n  (srst_n),
    .fire   (expire),
    .active (pulse_on)
  );

  assign host_power_ok = ~pulse_on;

  // R3: a load with an enable present leaves the timer armed
  p_load_arms_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (tmo_load && (sw_en || hw_strap)) |=> running);

  // R4: a load with no enable leaves the timer disarmed
  p_load_disarms_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (tmo_load && !sw_en && !hw_strap) |=> !running);

  // R6: cancel without the strap stops the timer
  p_cancel_stops_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (cancel_req && !hw_strap && !tmo_load) |=> !running);

  // R6: cancel under the strap leaves a running timer alone
  p_cancel_blocked_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (running && cancel_req && hw_strap && !tick_qs) |=> running);

  // R7: the power-good line drops right after an expiry
  p_expiry_drops_r7: assert property (@(posedge clk) disable iff (!srst_n)
    expire |=> (!host_power_ok && !running));

  // R11: a load with an enable overrides a same-cycle cancel
  p_load_over_cancel_r11: assert property (@(posedge clk) disable iff (!srst_n)
    (tmo_load && sw_en && cancel_req) |=> running);

endmodule

// File: tb/sim_host_watchdog.sv
module sim_host_watchdog;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned PULSE      = 36;
  localparam int unsigned WD_CYCLES  = 190000;

  // Each entry: {timeout code, expected ticks to expiry}
  localparam logic [18:0] VEC [8] = '{
    {3'd0, 16'd1},    {3'd1, 16'd4},    {3'd2, 16'd16},   {3'd3, 16'd64},
    {3'd4, 16'd240},  {3'd5, 16'd960},  {3'd6, 16'd3840}, {3'd7, 16'd15360}
  };

  logic       clk;
  logic       rst_n;
  logic       tick_qs;
  logic [2:0] tmo_code;
  logic       tmo_load;
  logic       sw_en;
  logic       hw_strap;
  logic       legacy_mode;
  logic       activity;
  logic       cancel_req;
  logic       host_power_ok;
  logic       running;

  int n_checks = 0;
  int n_fail   = 0;

  host_watchdog #(.PULSE_CYCLES(PULSE)) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_qs       (tick_qs),
    .tmo_code      (tmo_code),
    .tmo_load      (tmo_load),
    .sw_en         (sw_en),
    .hw_strap      (hw_strap),
    .legacy_mode   (legacy_mode),
    .activity      (activity),
    .cancel_req    (cancel_req),
    .host_power_ok (host_power_ok),
    .running       (running)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic give_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_qs = 1'b1;
      @(negedge clk);
    end
    tick_qs = 1'b0;
  endtask

  task automatic do_load(input logic [2:0] c);
    tmo_code = c;
    tmo_load = 1'b1;
    @(negedge clk);
    tmo_load = 1'b0;
  endtask

  task automatic measure_pulse(output int w);
    w = 0;
    while (!host_power_ok && w < 1000) begin
      w++;
      @(negedge clk);
    end
  endtask

  task automatic apply_reset(input logic legacy, input logic strap);
    @(negedge clk);
    legacy_mode = legacy;
    hw_strap    = strap;
    rst_n       = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * WD_CYCLES);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int w;
    rst_n = 1'b0; tick_qs = 1'b0; tmo_code = 3'd0; tmo_load = 1'b0;
    sw_en = 1'b0; hw_strap = 1'b0; legacy_mode = 1'b0;
    activity = 1'b0; cancel_req = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state, during reset and after release
    check("R1", "running in reset", running, 0);
    check("R1", "power ok in reset", host_power_ok, 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1", "running after release", running, 0);
    check("R1", "power ok after release", host_power_ok, 1);

    // R2 / R7 / R8 table walk
    for (int k = 0; k < 8; k++) begin
      sw_en = 1'b1;
      do_load(VEC[k][18:16]);
      check("R3", "armed by load", running, 1);
      give_ticks(int'(VEC[k][15:0]) - 1);
      check("R2", "alive one tick before timeout", running, 1);
      check("R2", "no pulse before timeout", host_power_ok, 1);
      give_ticks(1);
      check("R7", "stopped at expiry", running, 0);
      check("R7", "pulse low at expiry", host_power_ok, 0);
      measure_pulse(w);
      check("R7", "pulse width", w, PULSE);
      sw_en = 1'b0;
      give_ticks(3);
      check("R8", "idle after expiry", running, 0);
      check("R8", "no new pulse after expiry", host_power_ok, 1);
    end

    // R3: reload on a repeated start while running
    sw_en = 1'b1;
    do_load(3'd1);
    give_ticks(3);
    do_load(3'd1);
    give_ticks(3);
    check("R3", "restart reloaded count", running, 1);
    give_ticks(1);
    check("R3", "expires a full timeout after restart", running, 0);
    measure_pulse(w);

    // R4: load without enables stops a running timer
    do_load(3'd2);
    sw_en = 1'b0;
    do_load(3'd2);
    check("R4", "disarmed by load", running, 0);
    give_ticks(20);
    check("R4", "no pulse when disarmed", host_power_ok, 1);

    // R5: refill while running, none while idle
    sw_en = 1'b1;
    do_load(3'd1);
    give_ticks(3);
    activity = 1'b1; @(negedge clk); activity = 1'b0;
    give_ticks(3);
    check("R5", "refill extends count", running, 1);
    give_ticks(1);
    check("R5", "expiry after refill", running, 0);
    measure_pulse(w);
    activity = 1'b1; @(negedge clk); activity = 1'b0;
    check("R5", "refill ignored while idle", running, 0);
    give_ticks(5);
    check("R5", "no pulse after idle refill", host_power_ok, 1);

    // R6: cancel with and without the strap
    do_load(3'd1);
    cancel_req = 1'b1; @(negedge clk); cancel_req = 1'b0;
    check("R6", "cancel stops without strap", running, 0);
    sw_en = 1'b0;
    hw_strap = 1'b1;
    do_load(3'd1);
    give_ticks(2);
    cancel_req = 1'b1; @(negedge clk); cancel_req = 1'b0;
    check("R6", "cancel blocked by strap", running, 1);
    give_ticks(1);
    check("R6", "count untouched by blocked cancel", running, 1);
    give_ticks(1);
    check("R6", "expires on original schedule", host_power_ok, 0);
    measure_pulse(w);
    hw_strap = 1'b0;

    // R10: refill and final tick in one cycle
    sw_en = 1'b1;
    do_load(3'd1);
    give_ticks(3);
    activity = 1'b1; tick_qs = 1'b1; @(negedge clk);
    activity = 1'b0; tick_qs = 1'b0;
    check("R10", "refill beats final tick", running, 1);
    check("R10", "no pulse on collision", host_power_ok, 1);
    give_ticks(3);
    check("R10", "full timeout after collision", running, 1);
    give_ticks(1);
    check("R10", "expiry after collision", running, 0);
    measure_pulse(w);

    // R11: load and cancel in one cycle
    tmo_code = 3'd2; tmo_load = 1'b1; cancel_req = 1'b1; @(negedge clk);
    tmo_load = 1'b0; cancel_req = 1'b0;
    check("R11", "load wins over cancel", running, 1);
    sw_en = 1'b0;
    do_load(3'd2);

    // R9: legacy mode with strap arms at reset with 960 ticks
    apply_reset(1'b1, 1'b1);
    check("R9", "armed after legacy reset", running, 1);
    give_ticks(959);
    check("R9", "alive before default timeout", running, 1);
    give_ticks(1);
    check("R9", "expiry at default timeout", running, 0);
    check("R9", "pulse at default timeout", host_power_ok, 0);
    measure_pulse(w);
    apply_reset(1'b0, 1'b1);
    check("R1", "strap alone does not arm at reset", running, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule